// File: doc/BRIEF.md
# Accumulator Read Shifter and Limiter

This block formats data moving between a 56-bit accumulator and a 24-bit data bus. The accumulator is an 8-bit extension above a 24-bit high word and a 24-bit low word. On the read side, reading the whole accumulator first applies a one-bit scaling shift chosen by a two-bit mode. The block then tests whether the integer field of the shifted value is in use. If it is, the block returns a saturation constant of the destination width in place of the truncated value. Destinations may be one word (24 bits) or a word pair (48 bits). Each limiting event raises a one-cycle flag that the status logic can latch.

Reading a single part (high word, low word or extension) returns the raw part with no shift and no limiting. The extension is sign-extended to bus width. On the write side, the block formats a 24-bit bus word for one of four destinations: the full accumulator, the high word, the low word or the extension. It returns the formatted 56-bit value together with a per-part write enable. Both sides are combinational, followed by one register stage.

Top module: `acc_move_fmt`

## Requirements
- R1: For full-accumulator reads (source codes 0 and 1), scale_i selects the shift applied before any test. 2'b00 means no shift. 2'b01 means a 1-bit arithmetic right shift. 2'b10 means a 1-bit left shift with a zero entering bit 0. 2'b11 behaves as 2'b00.
- R2: With source code 0 (one-word destination), the shifted value is limited when any of its bits 55..47 differs from bit 55 of the unshifted accumulator. When limited, rd_data_o[23:0] is 0x7FFFFF if unshifted bit 55 is 0 and 0x800000 if it is 1, and rd_data_o[47:24] is zero.
- R3: With source code 1 (word-pair destination), the same test applies. The limited output is 0x7FFFFFFFFFFF for a positive accumulator and 0x800000000000 for a negative one.
- R4: When no limiting occurs, source code 0 returns shifted bits 47..24 in rd_data_o[23:0] with rd_data_o[47:24] zero. Source code 1 returns shifted bits 47..0.
- R5: Source code 2 returns the high word (accumulator bits 47..24) and source code 3 returns the low word (bits 23..0), both in rd_data_o[23:0]. Neither is shifted, and neither ever limits.
- R6: Source code 4 returns the extension byte in rd_data_o[7:0], with bits 23..8 copies of accumulator bit 55 and bits 47..24 zero. Source codes 5 to 7 return zero with no limit.
- R7: rd_limit_o is high only in the cycle where rd_valid_o presents a limited read. It is low for every other cycle, including the cycle after a limited read once rd_valid_i has dropped.
- R8: Write destination code 0 (full accumulator) yields wr_acc_o = {8 copies of wr_data_i[23], wr_data_i, 24 zeros} with wr_en_o = 3'b111. Enable bit 2 marks the extension, bit 1 the high word and bit 0 the low word.
- R9: Destination code 1 places wr_data_i in bits 47..24 with wr_en_o = 3'b010. Code 2 places it in bits 23..0 with wr_en_o = 3'b001. Code 3 places wr_data_i[7:0] in bits 55..48 with wr_en_o = 3'b100. In each case, bits not written are zero, and there is no sign extension or zero fill.
- R10: All outputs are registered with one cycle of latency. Reset clears them. A cycle without rd_valid_i (or wr_valid_i) yields zero read outputs (or zero write outputs) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | Read request this cycle |
| rd_src_i | input | 3 | Read source and destination code |
| scale_i | input | 2 | Scaling mode |
| acc_i | input | 56 | Accumulator contents |
| wr_valid_i | input | 1 | Write request this cycle |
| wr_dst_i | input | 2 | Write destination code |
| wr_data_i | input | 24 | Bus word to be written |
| rd_valid_o | output | 1 | Registered read valid |
| rd_data_o | output | 48 | Formatted read data |
| rd_limit_o | output | 1 | Limiting occurred on this read |
| wr_en_o | output | 3 | Per-part write enable (ext, high, low) |
| wr_acc_o | output | 56 | Formatted accumulator write value |

## Verification
The read path is driven with accumulators placed just inside and just outside the integer field for each scaling mode. Those pairs separate a test on the shifted value from a test on the raw extension. Matching positive and negative overflows show that the constant follows the unshifted sign. Part-source reads use values that would limit if read as a whole, which confirms that neither the shift nor saturation reaches them. Random accumulators with random modes are then compared against a model written from the requirements. Write vectors with both signs of bit 23 separate sign extension from zero fill for each destination.

// File: rtl/acc_fmt_pkg.sv
package acc_fmt_pkg;
  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  typedef enum logic [2:0] {
    SRC_FULL1 = 3'd0,
    SRC_FULL2 = 3'd1,
    SRC_HI    = 3'd2,
    SRC_LO    = 3'd3,
    SRC_EXT   = 3'd4
  } rd_src_e;

  typedef enum logic [1:0] {
    DST_FULL = 2'd0,
    DST_HI   = 2'd1,
    DST_LO   = 2'd2,
    DST_EXT  = 2'd3
  } wr_dst_e;
endpackage

// File: rtl/acc_scaler.sv
module acc_scaler
  import acc_fmt_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_i,
  input  logic [1:0]                scale_i,
  output logic [EXT_W+2*WORD_W-1:0] shifted_o,
  output logic                      int_used_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int DBL_W = 2*WORD_W;
  localparam int INT_W = ACC_W - DBL_W + 1;

  logic sign;
  assign sign = acc_i[ACC_W-1];

  always_comb begin
    unique case (scale_e'(scale_i))
      SCL_DOWN: shifted_o = {sign, acc_i[ACC_W-1:1]};
      SCL_UP:   shifted_o = {acc_i[ACC_W-2:0], 1'b0};
      default:  shifted_o = acc_i;
    endcase
  end

  // integer field compared against the pre-shift sign
  assign int_used_o = |(shifted_o[ACC_W-1:DBL_W-1] ^ {INT_W{sign}});
endmodule

// File: rtl/acc_limiter.sv
module acc_limiter
  import acc_fmt_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_i,
  input  logic [EXT_W+2*WORD_W-1:0] shifted_i,
  input  logic                      int_used_i,
  input  logic [2:0]                src_i,
  output logic [2*WORD_W-1:0]       data_o,
  output logic                      limit_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int DBL_W = 2*WORD_W;
  localparam logic [WORD_W-1:0] POS_1 = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] NEG_1 = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [DBL_W-1:0]  POS_2 = {1'b0, {(DBL_W-1){1'b1}}};
  localparam logic [DBL_W-1:0]  NEG_2 = {1'b1, {(DBL_W-1){1'b0}}};

  logic sign;
  assign sign = acc_i[ACC_W-1];

  always_comb begin
    data_o  = '0;
    limit_o = 1'b0;
    unique case (src_i)
      SRC_FULL1: begin
        limit_o = int_used_i;
        data_o[WORD_W-1:0] = int_used_i ? (sign ? NEG_1 : POS_1)
                                        : shifted_i[DBL_W-1:WORD_W];
      end
      SRC_FULL2: begin
        limit_o = int_used_i;
        data_o  = int_used_i ? (sign ? NEG_2 : POS_2) : shifted_i[DBL_W-1:0];
      end
      SRC_HI:  data_o[WORD_W-1:0] = acc_i[DBL_W-1:WORD_W];
      SRC_LO:  data_o[WORD_W-1:0] = acc_i[WORD_W-1:0];
      SRC_EXT: data_o[WORD_W-1:0] = {{(WORD_W-EXT_W){sign}}, acc_i[ACC_W-1:DBL_W]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_wr_formatter.sv
module acc_wr_formatter
  import acc_fmt_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic [1:0]                dst_i,
  input  logic [WORD_W-1:0]         data_i,
  output logic [EXT_W+2*WORD_W-1:0] acc_o,
  output logic [2:0]                en_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int DBL_W = 2*WORD_W;

  always_comb begin
    acc_o = '0;
    en_o  = '0;
    unique case (wr_dst_e'(dst_i))
      DST_FULL: begin
        acc_o = {{EXT_W{data_i[WORD_W-1]}}, data_i, {WORD_W{1'b0}}};
        en_o  = 3'b111;
      end
      DST_HI: begin
        acc_o[DBL_W-1:WORD_W] = data_i;
        en_o = 3'b010;
      end
      DST_LO: begin
        acc_o[WORD_W-1:0] = data_i;
        en_o = 3'b001;
      end
      default: begin
        acc_o[ACC_W-1:DBL_W] = data_i[EXT_W-1:0];
        en_o = 3'b100;
      end
    endcase
  end
endmodule

// File: rtl/acc_move_fmt.sv
module acc_move_fmt
  import acc_fmt_pkg::*;
#(
  parameter int EXT_W  = 8,
  parameter int WORD_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rd_valid_i,
  input  logic [2:0]                rd_src_i,
  input  logic [1:0]                scale_i,
  input  logic [EXT_W+2*WORD_W-1:0] acc_i,
  input  logic                      wr_valid_i,
  input  logic [1:0]                wr_dst_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  output logic                      rd_valid_o,
  output logic [2*WORD_W-1:0]       rd_data_o,
  output logic                      rd_limit_o,
  output logic [2:0]                wr_en_o,
  output logic [EXT_W+2*WORD_W-1:0] wr_acc_o
);
  localparam int ACC_W = EXT_W + 2*WORD_W;
  localparam int DBL_W = 2*WORD_W;

  logic [ACC_W-1:0] shifted;
  logic             int_used;
  logic [DBL_W-1:0] rd_data_d;
  logic             rd_limit_d;
  logic [ACC_W-1:0] wr_acc_d;
  logic [2:0]       wr_en_d;

  acc_scaler #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_scaler (
    .acc_i      (acc_i),
    .scale_i    (scale_i),
    .shifted_o  (shifted),
    .int_used_o (int_used)
  );

  acc_limiter #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_limiter (
    .acc_i      (acc_i),
    .shifted_i  (shifted),
    .int_used_i (int_used),
    .src_i      (rd_src_i),
    .data_o     (rd_data_d),
    .limit_o    (rd_limit_d)
  );

  acc_wr_formatter #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_wr_fmt (
    .dst_i  (wr_dst_i),
    .data_i (wr_data_i),
    .acc_o  (wr_acc_d),
    .en_o   (wr_en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_limit_o <= 1'b0;
      wr_en_o    <= '0;
      wr_acc_o   <= '0;
    end else begin
      rd_valid_o <= rd_valid_i;
      rd_data_o  <= rd_valid_i ? rd_data_d : '0;
      rd_limit_o <= rd_valid_i & rd_limit_d;
      wr_en_o    <= wr_valid_i ? wr_en_d : '0;
      wr_acc_o   <= wr_valid_i ? wr_acc_d : '0;
    end
  end

  // R7
  limit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_limit_o |-> rd_valid_o);

  // R10
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (!rd_valid_o && !rd_limit_o && rd_data_o == '0));

  // R5
  part_no_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && (rd_src_i == SRC_HI || rd_src_i == SRC_LO || rd_src_i == SRC_EXT))
      |=> !rd_limit_o);

  // R2
  sat_one_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_src_i == SRC_FULL1) |=>
      (!rd_limit_o || rd_data_o == {{WORD_W{1'b0}}, 1'b0, {(WORD_W-1){1'b1}}}
                   || rd_data_o == {{WORD_W{1'b0}}, 1'b1, {(WORD_W-1){1'b0}}}));

  // R8
  full_write_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_dst_i == DST_FULL) |=>
      (wr_acc_o[WORD_W-1:0] == '0 && wr_en_o == 3'b111 &&
       (wr_acc_o[ACC_W-1:DBL_W-1] == '0 || wr_acc_o[ACC_W-1:DBL_W-1] == '1)));

  // R9
  part_write_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_dst_i != DST_FULL) |=> $countones(wr_en_o) == 1);
endmodule

// File: tb/acc_move_fmt_test.sv
`timescale 1ns/1ps
module acc_move_fmt_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_valid_i = 1'b0;
  logic [2:0]  rd_src_i = '0;
  logic [1:0]  scale_i = '0;
  logic [55:0] acc_i = '0;
  logic        wr_valid_i = 1'b0;
  logic [1:0]  wr_dst_i = '0;
  logic [23:0] wr_data_i = '0;
  logic        rd_valid_o;
  logic [47:0] rd_data_o;
  logic        rd_limit_o;
  logic [2:0]  wr_en_o;
  logic [55:0] wr_acc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  acc_move_fmt uut (
    .clk_i, .rst_ni, .rd_valid_i, .rd_src_i, .scale_i, .acc_i,
    .wr_valid_i, .wr_dst_i, .wr_data_i,
    .rd_valid_o, .rd_data_o, .rd_limit_o, .wr_en_o, .wr_acc_o
  );

  // {scale, src, acc, expected data, expected limit}
  localparam int NRD = 18;
  localparam logic [109:0] RD_VEC [NRD] = '{
    {2'b00, 3'd0, 56'h00_123456_789ABC, 48'h000000_123456, 1'b0},
    {2'b00, 3'd0, 56'h01_000000_000000, 48'h000000_7FFFFF, 1'b1},
    {2'b00, 3'd0, 56'hFE_800000_000000, 48'h000000_800000, 1'b1},
    {2'b00, 3'd0, 56'hFF_800000_000000, 48'h000000_800000, 1'b0},
    {2'b10, 3'd0, 56'h00_400000_000000, 48'h000000_7FFFFF, 1'b1},
    {2'b10, 3'd0, 56'h00_200000_000001, 48'h000000_400000, 1'b0},
    {2'b01, 3'd0, 56'h00_800000_000000, 48'h000000_400000, 1'b0},
    {2'b01, 3'd0, 56'h01_000000_000000, 48'h000000_7FFFFF, 1'b1},
    {2'b11, 3'd0, 56'h00_800000_000000, 48'h000000_7FFFFF, 1'b1},
    {2'b00, 3'd1, 56'h00_123456_789ABC, 48'h123456_789ABC, 1'b0},
    {2'b00, 3'd1, 56'h80_000000_000000, 48'h800000_000000, 1'b1},
    {2'b01, 3'd1, 56'h00_000000_000003, 48'h000000_000001, 1'b0},
    {2'b00, 3'd2, 56'h7F_ABCDEF_123456, 48'h000000_ABCDEF, 1'b0},
    {2'b10, 3'd2, 56'h7F_ABCDEF_123456, 48'h000000_ABCDEF, 1'b0},
    {2'b00, 3'd3, 56'h7F_ABCDEF_123456, 48'h000000_123456, 1'b0},
    {2'b00, 3'd4, 56'h80_000000_000000, 48'h000000_FFFF80, 1'b0},
    {2'b00, 3'd4, 56'h7F_000000_000000, 48'h000000_00007F, 1'b0},
    {2'b01, 3'd0, 56'hFF_000000_000001, 48'h000000_800000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [48:0] model_rd(input logic [1:0] scl, input logic [2:0] src,
                                           input logic [55:0] a);
    logic [55:0] s;
    logic        used;
    logic [47:0] d;
    s = a;
    if (scl == 2'b01) s = {a[55], a[55:1]};
    if (scl == 2'b10) s = {a[54:0], 1'b0};
    used = 1'b0;
    for (int i = 47; i <= 55; i++) if (s[i] != a[55]) used = 1'b1;
    d = '0;
    case (src)
      3'd0: d[23:0] = used ? (a[55] ? 24'h800000 : 24'h7FFFFF) : s[47:24];
      3'd1: d = used ? (a[55] ? 48'h800000_000000 : 48'h7FFFFF_FFFFFF) : s[47:0];
      3'd2: d[23:0] = a[47:24];
      3'd3: d[23:0] = a[23:0];
      3'd4: d[23:0] = {{16{a[55]}}, a[55:48]};
      default: d = '0;
    endcase
    return {used && (src < 3'd2), d};
  endfunction

  task automatic do_read(input logic [1:0] scl, input logic [2:0] src, input logic [55:0] a,
                         input logic [47:0] ed, input logic el, input string req);
    rd_valid_i = 1'b1; scale_i = scl; rd_src_i = src; acc_i = a;
    @(negedge clk_i);
    check(rd_valid_o && rd_data_o == ed, req, {16'h0, rd_data_o}, {16'h0, ed});
    check(rd_limit_o == el, "R7 limit flag", {63'h0, rd_limit_o}, {63'h0, el});
  endtask

  task automatic do_write(input logic [1:0] dst, input logic [23:0] d,
                          input logic [55:0] ea, input logic [2:0] ee, input string req);
    wr_valid_i = 1'b1; wr_dst_i = dst; wr_data_i = d;
    @(negedge clk_i);
    check(wr_acc_o == ea && wr_en_o == ee, req, {5'h0, wr_en_o, wr_acc_o}, {5'h0, ee, ea});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rd_valid_i = 1'b1; acc_i = 56'h01_000000_000000; wr_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(!rd_valid_o && rd_data_o == '0 && !rd_limit_o && wr_en_o == '0 && wr_acc_o == '0,
          "R10 reset", {15'h0, rd_valid_o, rd_data_o}, 64'h0);
    rd_valid_i = 1'b0; wr_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R2 R3 R4 R5 R6 table walk
    for (int i = 0; i < NRD; i++) begin
      logic [109:0] v;
      v = RD_VEC[i];
      do_read(v[109:108], v[107:105], v[104:49], v[48:1], v[0], "R1/R2/R3/R4/R5/R6 table");
    end

    // R7 limit falls when valid drops after a limited read
    do_read(2'b00, 3'd0, 56'h01_000000_000000, 48'h7FFFFF, 1'b1, "R2 limited read");
    rd_valid_i = 1'b0;
    @(negedge clk_i);
    check(!rd_limit_o && !rd_valid_o, "R7 one-cycle pulse", {62'h0, rd_valid_o, rd_limit_o}, 64'h0);
    // R10 idle read outputs zero even with limiting accumulator
    check(rd_data_o == '0, "R10 idle zero", {16'h0, rd_data_o}, 64'h0);

    // R6 unused source codes
    do_read(2'b00, 3'd5, 56'h80_FFFFFF_FFFFFF, 48'h0, 1'b0, "R6 code 5");
    do_read(2'b10, 3'd7, 56'h01_000000_000000, 48'h0, 1'b0, "R6 code 7");

    // R5 part sources never limit on an overflowing accumulator
    do_read(2'b10, 3'd3, 56'h40_000000_00ABCD, 48'h00ABCD, 1'b0, "R5 low no limit");

    // random against model
    for (int i = 0; i < 300; i++) begin
      logic [55:0] a;
      logic [1:0]  s;
      logic [2:0]  c;
      logic [48:0] m;
      a = {$urandom, $urandom};
      if (i % 3 == 0) a[55:45] = {11{a[44]}};
      s = 2'($urandom);
      c = 3'($urandom_range(0, 4));
      m = model_rd(s, c, a);
      do_read(s, c, a, m[47:0], m[48], "R1/R2/R3/R4 random");
    end
    rd_valid_i = 1'b0;

    // R8 full write
    do_write(2'd0, 24'h800001, 56'hFF_800001_000000, 3'b111, "R8 full neg");
    do_write(2'd0, 24'h7FFFFF, 56'h00_7FFFFF_000000, 3'b111, "R8 full pos");
    // R9 part writes
    do_write(2'd1, 24'h800001, 56'h00_800001_000000, 3'b010, "R9 high");
    do_write(2'd2, 24'h800001, 56'h00_000000_800001, 3'b001, "R9 low");
    do_write(2'd3, 24'h1234AB, 56'hAB_000000_000000, 3'b100, "R9 ext");
    wr_valid_i = 1'b0;
    @(negedge clk_i);
    check(wr_en_o == '0 && wr_acc_o == '0, "R10 idle write", {5'h0, wr_en_o, wr_acc_o}, 64'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule